// File: doc/BRIEF.md
# Processor Mailbox and Event Interrupt Controller

This block carries short messages between on-chip firmware and an external application processor (AP). Two 64-bit message registers are provided: an outbound one that firmware fills and the AP reads, and an inbound one that the AP fills and firmware reads. Posting a message means writing the upper 32-bit word. That write raises a "full" flag toward the reader. The reader acknowledges by clearing that flag, and the clear raises an "empty" indication back toward the writer.

The AP sees an event register. Its mailbox and wakeup bits are sticky: hardware sets them and the AP clears them by writing ones. Its two DMA status bits follow live inputs. The event register, ANDed with two separate AP-programmed masks, drives a registered interrupt line and a registered DMA request line. Each line has its own polarity control. Firmware has its own small status register, with two write-one-to-clear flags, and a firmware interrupt line.

Both register ports are simple: write strobe, word address, per-byte enables, write data, and read data returned one clock after the address is presented.

Top module: `mbox_evt_ctrl`

## Requirements
- R1: After reset both mailboxes read zero, the AP event register (AP address 4) reads 0x4000 with the DMA inputs low, the firmware status register (firmware address 4) reads 0, the masks read 0, and intr_o, drq_o and fw_intr_o are 0.
- R2: Firmware writes the outbound message at firmware addresses 0 (low word) and 1 (high word). The AP writes the inbound message at AP addresses 2 and 3. Each write updates only the bytes whose enable is set. Both ports read the outbound message at addresses 0/1 and the inbound message at 2/3, with read data valid one clock after the address.
- R3: A firmware write to address 1 with any byte enable set sets event bit 13 (outbound full). A write to address 0 leaves that bit unchanged.
- R4: The AP writing 1 to event bit 13 while it is set clears it and sets firmware status bit 0 (outbound empty). Firmware clears status bit 0 by writing 1 to it.
- R5: An AP write to address 3 with any byte enable set clears event bit 14 (inbound empty) and sets firmware status bit 1 (inbound full). Firmware writing 1 to status bit 1 while it is set clears it and sets bit 14 once. The AP may also clear bit 14 by writing 1, and a later firmware clear with bit 1 already 0 does not set bit 14 again.
- R6: A one-cycle pulse on wakeup_i sets event bit 15. The bit stays set until the AP writes 1 to it. Writing 0 leaves it set.
- R7: Event bit 12 shows dma_ready_i and bit 11 shows dma_wmark_i, each one clock later. AP writes to these bits have no effect.
- R8: intr_o equals the OR over all bits of (event AND interrupt mask, AP address 5), inverted when polarity bit 0 is 1. It updates at the clock edge that updates the event or mask.
- R9: drq_o is formed the same way from the DMA request mask (AP address 6), inverted when polarity bit 1 is 1.
- R10: The polarity register (AP address 7) resets to 0 (both lines active-high). A write to it changes the line levels at the same clock edge.
- R11: When a hardware set and an AP write-one-to-clear reach the same sticky event bit in the same cycle, the bit ends up set. An outbound post in the same cycle as the AP's clear of bit 13 leaves firmware status bit 0 unchanged.
- R12: fw_intr_o is 1 exactly when firmware status bit 0 or bit 1 is set, and is updated at the same edge as those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fw_we | input | 1 | Firmware write strobe |
| fw_addr | input | ADDR_W | Firmware word address |
| fw_be | input | WORD_W/8 | Firmware byte enables |
| fw_wdata | input | WORD_W | Firmware write data |
| fw_rdata | output | WORD_W | Firmware read data, one clock after address |
| ap_we | input | 1 | AP write strobe |
| ap_addr | input | ADDR_W | AP word address |
| ap_be | input | WORD_W/8 | AP byte enables |
| ap_wdata | input | WORD_W | AP write data |
| ap_rdata | output | WORD_W | AP read data, one clock after address |
| dma_ready_i | input | 1 | Live DMA ready status |
| dma_wmark_i | input | 1 | Live DMA watermark status |
| wakeup_i | input | 1 | Return-from-standby pulse |
| intr_o | output | 1 | Masked AP interrupt, selectable polarity |
| drq_o | output | 1 | Masked DMA request, selectable polarity |
| fw_intr_o | output | 1 | Firmware mailbox interrupt |

## Verification
Every result of this block is due exactly one clock edge after its cause. Flags, masks and the two masked lines change at the edge that captures a write or a status input. Read data reflects state from before the edge that samples the address, so a read placed right after a write sees that write. The bench drives inputs on the falling edge and advances a behavioural model on the rising edge. On each following falling edge it compares both read buses and all three interrupt lines with the model. Directed checks also read registers back one cycle after their address, and probe the lines right after the edge that followed the stimulus.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Event register bit positions (visible to AP software).
  localparam int EV_WMARK    = 11;
  localparam int EV_READY    = 12;
  localparam int EV_RD_FULL  = 13;
  localparam int EV_WR_EMPTY = 14;
  localparam int EV_WAKE     = 15;

  // Firmware status bit positions.
  localparam int FS_RD_EMPTY = 0;
  localparam int FS_WR_FULL  = 1;

  // Polarity register bit positions.
  localparam int POL_INTR = 0;
  localparam int POL_DRQ  = 1;

  typedef enum logic [2:0] {
    A_OUT_LO = 3'd0,
    A_OUT_HI = 3'd1,
    A_IN_LO  = 3'd2,
    A_IN_HI  = 3'd3,
    A_STAT   = 3'd4,
    A_IMASK  = 3'd5,
    A_DMASK  = 3'd6,
    A_POL    = 3'd7
  } reg_addr_e;

endpackage

// File: rtl/mbox_flag.sv
module mbox_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q,
  output logic q_nxt
);

  // Set dominates clear so a coincident event is never lost.
  assign q_nxt = set | (q & ~clr);

  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= q_nxt;
  end

  a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
    set |=> q);

endmodule

// File: rtl/mbox_msg_reg.sv
module mbox_msg_reg #(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [WORD_W-1:0]   wmask,
  input  logic [WORD_W-1:0]   wdata,
  output logic [2*WORD_W-1:0] msg,
  output logic                post
);

  logic [WORD_W-1:0] lo_q, hi_q;

  assign msg  = {hi_q, lo_q};
  assign post = wr_hi & (|wmask);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_lo) lo_q <= (lo_q & ~wmask) | (wdata & wmask);
      if (wr_hi) hi_q <= (hi_q & ~wmask) | (wdata & wmask);
    end
  end

endmodule

// File: rtl/mbox_irq_out.sv
module mbox_irq_out #(
  parameter int EVT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_W-1:0] bits,
  input  logic [EVT_W-1:0] mask,
  input  logic             active_low,
  output logic             line
);

  always_ff @(posedge clk) begin
    if (rst) line <= 1'b0;
    else     line <= active_low ^ (|(bits & mask));
  end

endmodule

// File: rtl/mbox_evt_ctrl.sv
module mbox_evt_ctrl
  import mbox_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 3,
  parameter int EVT_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fw_we,
  input  logic [ADDR_W-1:0]   fw_addr,
  input  logic [WORD_W/8-1:0] fw_be,
  input  logic [WORD_W-1:0]   fw_wdata,
  output logic [WORD_W-1:0]   fw_rdata,
  input  logic                ap_we,
  input  logic [ADDR_W-1:0]   ap_addr,
  input  logic [WORD_W/8-1:0] ap_be,
  input  logic [WORD_W-1:0]   ap_wdata,
  output logic [WORD_W-1:0]   ap_rdata,
  input  logic                dma_ready_i,
  input  logic                dma_wmark_i,
  input  logic                wakeup_i,
  output logic                intr_o,
  output logic                drq_o,
  output logic                fw_intr_o
);

  localparam int BE_W  = WORD_W / 8;
  localparam int MSG_W = 2 * WORD_W;

  // Byte enables expanded to bit masks.
  logic [WORD_W-1:0] fw_wmask, ap_wmask;
  for (genvar b = 0; b < BE_W; b++) begin : g_be
    assign fw_wmask[8*b +: 8] = {8{fw_be[b]}};
    assign ap_wmask[8*b +: 8] = {8{ap_be[b]}};
  end

  // Address decode.
  logic fw_out_lo, fw_out_hi, fw_stat_wr;
  logic ap_in_lo, ap_in_hi, ap_stat_wr, ap_imask_wr, ap_dmask_wr, ap_pol_wr;
  assign fw_out_lo   = fw_we && fw_addr == ADDR_W'(A_OUT_LO);
  assign fw_out_hi   = fw_we && fw_addr == ADDR_W'(A_OUT_HI);
  assign fw_stat_wr  = fw_we && fw_addr == ADDR_W'(A_STAT);
  assign ap_in_lo    = ap_we && ap_addr == ADDR_W'(A_IN_LO);
  assign ap_in_hi    = ap_we && ap_addr == ADDR_W'(A_IN_HI);
  assign ap_stat_wr  = ap_we && ap_addr == ADDR_W'(A_STAT);
  assign ap_imask_wr = ap_we && ap_addr == ADDR_W'(A_IMASK);
  assign ap_dmask_wr = ap_we && ap_addr == ADDR_W'(A_DMASK);
  assign ap_pol_wr   = ap_we && ap_addr == ADDR_W'(A_POL);

  // Message registers.
  logic [MSG_W-1:0] out_msg, in_msg;
  logic             fw_post, ap_post;

  mbox_msg_reg #(.WORD_W(WORD_W)) u_out_msg (
    .clk(clk), .rst(rst), .wr_lo(fw_out_lo), .wr_hi(fw_out_hi),
    .wmask(fw_wmask), .wdata(fw_wdata), .msg(out_msg), .post(fw_post)
  );

  mbox_msg_reg #(.WORD_W(WORD_W)) u_in_msg (
    .clk(clk), .rst(rst), .wr_lo(ap_in_lo), .wr_hi(ap_in_hi),
    .wmask(ap_wmask), .wdata(ap_wdata), .msg(in_msg), .post(ap_post)
  );

  // Write-one-to-clear requests.
  logic ap_clr_full, ap_clr_empty, ap_clr_wake, fw_clr_rd_empty, fw_clr_wr_full;
  assign ap_clr_full     = ap_stat_wr & ap_wdata[EV_RD_FULL]  & ap_wmask[EV_RD_FULL];
  assign ap_clr_empty    = ap_stat_wr & ap_wdata[EV_WR_EMPTY] & ap_wmask[EV_WR_EMPTY];
  assign ap_clr_wake     = ap_stat_wr & ap_wdata[EV_WAKE]     & ap_wmask[EV_WAKE];
  assign fw_clr_rd_empty = fw_stat_wr & fw_wdata[FS_RD_EMPTY] & fw_wmask[FS_RD_EMPTY];
  assign fw_clr_wr_full  = fw_stat_wr & fw_wdata[FS_WR_FULL]  & fw_wmask[FS_WR_FULL];

  // Sticky flags.
  logic rd_full_q, rd_full_n, wr_empty_q, wr_empty_n, wake_q, wake_n;
  logic fw_rd_empty_q, fw_rd_empty_n, fw_wr_full_q, fw_wr_full_n;
  logic rd_empty_set, wr_empty_set;

  // Emptying events fire only when the full flag actually falls.
  assign rd_empty_set = ap_clr_full & rd_full_q & ~fw_post;
  assign wr_empty_set = fw_clr_wr_full & fw_wr_full_q & ~ap_post;

  mbox_flag #(.RST_VAL(1'b0)) u_rd_full (
    .clk(clk), .rst(rst), .set(fw_post), .clr(ap_clr_full),
    .q(rd_full_q), .q_nxt(rd_full_n)
  );
  mbox_flag #(.RST_VAL(1'b1)) u_wr_empty (
    .clk(clk), .rst(rst), .set(wr_empty_set), .clr(ap_post | ap_clr_empty),
    .q(wr_empty_q), .q_nxt(wr_empty_n)
  );
  mbox_flag #(.RST_VAL(1'b0)) u_wake (
    .clk(clk), .rst(rst), .set(wakeup_i), .clr(ap_clr_wake),
    .q(wake_q), .q_nxt(wake_n)
  );
  mbox_flag #(.RST_VAL(1'b0)) u_fw_rd_empty (
    .clk(clk), .rst(rst), .set(rd_empty_set), .clr(fw_clr_rd_empty),
    .q(fw_rd_empty_q), .q_nxt(fw_rd_empty_n)
  );
  mbox_flag #(.RST_VAL(1'b0)) u_fw_wr_full (
    .clk(clk), .rst(rst), .set(ap_post), .clr(fw_clr_wr_full),
    .q(fw_wr_full_q), .q_nxt(fw_wr_full_n)
  );

  // Live DMA status, sampled each clock.
  logic rdy_q, wm_q;
  always_ff @(posedge clk) begin
    rdy_q <= dma_ready_i;
    wm_q  <= dma_wmark_i;
  end

  logic [EVT_W-1:0] evt_q, evt_n;
  always_comb begin
    evt_q = '0;
    evt_q[EV_WMARK]    = wm_q;
    evt_q[EV_READY]    = rdy_q;
    evt_q[EV_RD_FULL]  = rd_full_q;
    evt_q[EV_WR_EMPTY] = wr_empty_q;
    evt_q[EV_WAKE]     = wake_q;
    evt_n = '0;
    evt_n[EV_WMARK]    = dma_wmark_i;
    evt_n[EV_READY]    = dma_ready_i;
    evt_n[EV_RD_FULL]  = rd_full_n;
    evt_n[EV_WR_EMPTY] = wr_empty_n;
    evt_n[EV_WAKE]     = wake_n;
  end

  // AP control registers.
  logic [EVT_W-1:0] imask_q, imask_n, dmask_q, dmask_n;
  logic [1:0]       pol_q, pol_n;
  assign imask_n = ap_imask_wr ? ((imask_q & ~ap_wmask[EVT_W-1:0]) | (ap_wdata[EVT_W-1:0] & ap_wmask[EVT_W-1:0])) : imask_q;
  assign dmask_n = ap_dmask_wr ? ((dmask_q & ~ap_wmask[EVT_W-1:0]) | (ap_wdata[EVT_W-1:0] & ap_wmask[EVT_W-1:0])) : dmask_q;
  assign pol_n   = ap_pol_wr   ? ((pol_q & ~ap_wmask[1:0]) | (ap_wdata[1:0] & ap_wmask[1:0])) : pol_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      imask_q <= '0;
      dmask_q <= '0;
      pol_q   <= '0;
    end else begin
      imask_q <= imask_n;
      dmask_q <= dmask_n;
      pol_q   <= pol_n;
    end
  end

  // Output lines, driven from next-state so they move with their cause.
  mbox_irq_out #(.EVT_W(EVT_W)) u_intr (
    .clk(clk), .rst(rst), .bits(evt_n), .mask(imask_n),
    .active_low(pol_n[POL_INTR]), .line(intr_o)
  );
  mbox_irq_out #(.EVT_W(EVT_W)) u_drq (
    .clk(clk), .rst(rst), .bits(evt_n), .mask(dmask_n),
    .active_low(pol_n[POL_DRQ]), .line(drq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) fw_intr_o <= 1'b0;
    else     fw_intr_o <= fw_rd_empty_n | fw_wr_full_n;
  end

  // Registered read ports.
  always_ff @(posedge clk) begin
    if (rst) begin
      fw_rdata <= '0;
      ap_rdata <= '0;
    end else begin
      case (fw_addr)
        ADDR_W'(A_OUT_LO): fw_rdata <= out_msg[WORD_W-1:0];
        ADDR_W'(A_OUT_HI): fw_rdata <= out_msg[MSG_W-1:WORD_W];
        ADDR_W'(A_IN_LO):  fw_rdata <= in_msg[WORD_W-1:0];
        ADDR_W'(A_IN_HI):  fw_rdata <= in_msg[MSG_W-1:WORD_W];
        ADDR_W'(A_STAT):   fw_rdata <= WORD_W'({fw_wr_full_q, fw_rd_empty_q});
        default:           fw_rdata <= '0;
      endcase
      case (ap_addr)
        ADDR_W'(A_OUT_LO): ap_rdata <= out_msg[WORD_W-1:0];
        ADDR_W'(A_OUT_HI): ap_rdata <= out_msg[MSG_W-1:WORD_W];
        ADDR_W'(A_IN_LO):  ap_rdata <= in_msg[WORD_W-1:0];
        ADDR_W'(A_IN_HI):  ap_rdata <= in_msg[MSG_W-1:WORD_W];
        ADDR_W'(A_STAT):   ap_rdata <= WORD_W'(evt_q);
        ADDR_W'(A_IMASK):  ap_rdata <= WORD_W'(imask_q);
        ADDR_W'(A_DMASK):  ap_rdata <= WORD_W'(dmask_q);
        ADDR_W'(A_POL):    ap_rdata <= WORD_W'(pol_q);
        default:           ap_rdata <= '0;
      endcase
    end
  end

  // Cross-side flag relations.
  a_r3_post_sets_full: assert property (@(posedge clk) disable iff (rst)
    (fw_out_hi && |fw_be) |=> rd_full_q);

  a_r4_ack_raises_empty: assert property (@(posedge clk) disable iff (rst)
    (ap_clr_full && rd_full_q && !fw_post) |=> (fw_rd_empty_q && !rd_full_q));

  a_r5_post_clears_empty: assert property (@(posedge clk) disable iff (rst)
    (ap_in_hi && |ap_be) |=> (!wr_empty_q && fw_wr_full_q));

  a_r6_wake_sticky: assert property (@(posedge clk) disable iff (rst)
    (wake_q && !ap_clr_wake) |=> wake_q);

  a_r7_ready_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (evt_q[EV_READY] == $past(dma_ready_i)));

  a_r12_fw_line: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (fw_intr_o == (fw_rd_empty_q | fw_wr_full_q)));

endmodule

// File: tb/mbox_evt_ctrl_test.sv
`timescale 1ns/1ps
module mbox_evt_ctrl_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fw_we = 1'b0, ap_we = 1'b0;
  logic [2:0]  fw_addr = '0, ap_addr = '0;
  logic [3:0]  fw_be = '0, ap_be = '0;
  logic [31:0] fw_wdata = '0, ap_wdata = '0;
  logic [31:0] fw_rdata, ap_rdata;
  logic        dma_ready_i = 1'b0, dma_wmark_i = 1'b0, wakeup_i = 1'b0;
  logic        intr_o, drq_o, fw_intr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mbox_evt_ctrl uut (
    .clk(clk), .rst(rst),
    .fw_we(fw_we), .fw_addr(fw_addr), .fw_be(fw_be), .fw_wdata(fw_wdata), .fw_rdata(fw_rdata),
    .ap_we(ap_we), .ap_addr(ap_addr), .ap_be(ap_be), .ap_wdata(ap_wdata), .ap_rdata(ap_rdata),
    .dma_ready_i(dma_ready_i), .dma_wmark_i(dma_wmark_i), .wakeup_i(wakeup_i),
    .intr_o(intr_o), .drq_o(drq_o), .fw_intr_o(fw_intr_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- Behavioural reference model ----------------
  logic [31:0] m_olo, m_ohi, m_ilo, m_ihi, m_imask, m_dmask;
  logic [1:0]  m_pol;
  bit m_full, m_wempty, m_wake, m_rdy, m_wm, m_fre, m_fwf;
  bit m_intr, m_drq, m_fwint;
  logic [31:0] m_ap_rd, m_fw_rd;
  bit m_valid = 1'b0;

  function automatic logic [31:0] bm(input logic [3:0] be);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = {8{be[i]}};
    return r;
  endfunction

  function automatic logic [31:0] m_evt();
    return {16'h0, m_wake, m_wempty, m_full, m_rdy, m_wm, 11'h0};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_olo = 0; m_ohi = 0; m_ilo = 0; m_ihi = 0; m_imask = 0; m_dmask = 0; m_pol = 0;
      m_full = 0; m_wempty = 1; m_wake = 0; m_fre = 0; m_fwf = 0;
      m_intr = 0; m_drq = 0; m_fwint = 0; m_ap_rd = 0; m_fw_rd = 0;
      m_rdy = dma_ready_i; m_wm = dma_wmark_i;
      m_valid = 1'b1;
    end else begin
      logic [31:0] fm, am, apc, fwc, ev;
      bit fpost, apost, was_full, was_fwf;
      fm = bm(fw_be); am = bm(ap_be);
      case (fw_addr)
        0: m_fw_rd = m_olo; 1: m_fw_rd = m_ohi; 2: m_fw_rd = m_ilo; 3: m_fw_rd = m_ihi;
        4: m_fw_rd = {30'h0, m_fwf, m_fre};
        default: m_fw_rd = 0;
      endcase
      case (ap_addr)
        0: m_ap_rd = m_olo; 1: m_ap_rd = m_ohi; 2: m_ap_rd = m_ilo; 3: m_ap_rd = m_ihi;
        4: m_ap_rd = m_evt(); 5: m_ap_rd = m_imask; 6: m_ap_rd = m_dmask;
        default: m_ap_rd = {30'h0, m_pol};
      endcase
      fpost = fw_we && fw_addr == 1 && fw_be != 0;
      apost = ap_we && ap_addr == 3 && ap_be != 0;
      apc = (ap_we && ap_addr == 4) ? (ap_wdata & am) : 0;
      fwc = (fw_we && fw_addr == 4) ? (fw_wdata & fm) : 0;
      was_full = m_full; was_fwf = m_fwf;
      if (fw_we && fw_addr == 0) m_olo = (m_olo & ~fm) | (fw_wdata & fm);
      if (fw_we && fw_addr == 1) m_ohi = (m_ohi & ~fm) | (fw_wdata & fm);
      if (ap_we && ap_addr == 2) m_ilo = (m_ilo & ~am) | (ap_wdata & am);
      if (ap_we && ap_addr == 3) m_ihi = (m_ihi & ~am) | (ap_wdata & am);
      if (ap_we && ap_addr == 5) m_imask = (m_imask & ~am) | (ap_wdata & am & 32'hFFFF);
      if (ap_we && ap_addr == 6) m_dmask = (m_dmask & ~am) | (ap_wdata & am & 32'hFFFF);
      if (ap_we && ap_addr == 7) m_pol = (m_pol & ~am[1:0]) | (ap_wdata[1:0] & am[1:0]);
      m_full   = fpost || (was_full && !apc[13]);
      m_fre    = (apc[13] && was_full && !fpost) || (m_fre && !fwc[0]);
      m_fwf    = apost || (was_fwf && !fwc[1]);
      m_wempty = (fwc[1] && was_fwf && !apost) || (m_wempty && !apc[14] && !apost);
      m_wake   = wakeup_i || (m_wake && !apc[15]);
      m_rdy = dma_ready_i; m_wm = dma_wmark_i;
      ev = m_evt();
      m_intr  = m_pol[0] ^ ((ev & m_imask) != 0);
      m_drq   = m_pol[1] ^ ((ev & m_dmask) != 0);
      m_fwint = m_fre || m_fwf;
    end
  end

  always @(negedge clk) begin
    if (m_valid && !done) begin
      chk("R8 intr_o vs model", {31'h0, intr_o}, {31'h0, m_intr});
      chk("R9 drq_o vs model", {31'h0, drq_o}, {31'h0, m_drq});
      chk("R12 fw_intr_o vs model", {31'h0, fw_intr_o}, {31'h0, m_fwint});
      chk("R2 ap_rdata vs model", ap_rdata, m_ap_rd);
      chk("R2 fw_rdata vs model", fw_rdata, m_fw_rd);
    end
  end

  // ---------------- Stimulus tasks (entered at a falling edge) ----------------
  task automatic fw_wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
    fw_we = 1; fw_addr = a; fw_wdata = d; fw_be = be;
    @(negedge clk);
    fw_we = 0; fw_be = 0;
  endtask

  task automatic ap_wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
    ap_we = 1; ap_addr = a; ap_wdata = d; ap_be = be;
    @(negedge clk);
    ap_we = 0; ap_be = 0;
  endtask

  task automatic ap_rd(input logic [2:0] a, output logic [31:0] d);
    ap_addr = a;
    @(negedge clk);
    d = ap_rdata;
  endtask

  task automatic fw_rd(input logic [2:0] a, output logic [31:0] d);
    fw_addr = a;
    @(negedge clk);
    d = fw_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    ap_rd(4, v); chk("R1 event reset", v, 32'h4000);
    fw_rd(4, v); chk("R1 fw status reset", v, 32'h0);
    ap_rd(5, v); chk("R1 intr mask reset", v, 32'h0);
    chk("R1 intr_o reset", {31'h0, intr_o}, 32'h0);
    chk("R1 drq_o reset", {31'h0, drq_o}, 32'h0);

    // R2/R3 outbound message
    fw_wr(0, 32'h1122_3344, 4'hF);
    ap_rd(4, v); chk("R3 low word does not set full", v, 32'h4000);
    fw_wr(1, 32'hAABB_CCDD, 4'b0011);
    ap_rd(1, v); chk("R2 outbound high partial bytes", v, 32'h0000_CCDD);
    ap_rd(0, v); chk("R2 outbound low", v, 32'h1122_3344);
    ap_rd(4, v); chk("R3 high word sets full", v, 32'h6000);

    // R8/R10 interrupt mask and polarity
    ap_wr(5, 32'h2000, 4'hF);
    chk("R8 intr on masked full", {31'h0, intr_o}, 32'h1);
    ap_wr(7, 32'h1, 4'hF);
    chk("R10 intr active-low", {31'h0, intr_o}, 32'h0);
    ap_wr(7, 32'h0, 4'hF);
    chk("R10 intr back active-high", {31'h0, intr_o}, 32'h1);

    // R4/R12 AP acknowledges outbound message
    ap_wr(4, 32'h2000, 4'hF);
    chk("R8 intr drops on clear", {31'h0, intr_o}, 32'h0);
    chk("R12 fw line on empty", {31'h0, fw_intr_o}, 32'h1);
    fw_rd(4, v); chk("R4 fw empty flag set", v, 32'h1);
    ap_rd(4, v); chk("R4 full cleared", v, 32'h4000);
    fw_wr(4, 32'h1, 4'hF);
    chk("R12 fw line cleared", {31'h0, fw_intr_o}, 32'h0);

    // R5 inbound message
    ap_wr(3, 32'h5566_7788, 4'hF);
    fw_rd(4, v); chk("R5 fw full flag", v, 32'h2);
    ap_rd(4, v); chk("R5 empty cleared by post", v, 32'h0);
    fw_rd(3, v); chk("R2 inbound high via fw", v, 32'h5566_7788);
    fw_wr(4, 32'h2, 4'hF);
    ap_rd(4, v); chk("R5 empty set on drain", v, 32'h4000);
    ap_wr(4, 32'h4000, 4'hF);
    ap_rd(4, v); chk("R5 AP clears empty", v, 32'h0);
    fw_wr(4, 32'h2, 4'hF);
    ap_rd(4, v); chk("R5 empty set only once", v, 32'h0);

    // R6 wakeup
    wakeup_i = 1; @(negedge clk); wakeup_i = 0;
    ap_rd(4, v); chk("R6 wakeup set", v, 32'h8000);
    ap_wr(4, 32'h0, 4'hF);
    ap_rd(4, v); chk("R6 write zero keeps wakeup", v, 32'h8000);
    ap_wr(4, 32'h8000, 4'hF);
    ap_rd(4, v); chk("R6 wakeup cleared", v, 32'h0);

    // R11 set beats clear
    wakeup_i = 1; ap_we = 1; ap_addr = 4; ap_wdata = 32'h8000; ap_be = 4'hF;
    @(negedge clk);
    wakeup_i = 0; ap_we = 0; ap_be = 0;
    ap_rd(4, v); chk("R11 wakeup set wins", v, 32'h8000);
    ap_wr(4, 32'h8000, 4'hF);
    fw_wr(1, 32'h0102_0304, 4'hF);
    fw_we = 1; fw_addr = 1; fw_wdata = 32'h0506_0708; fw_be = 4'hF;
    ap_we = 1; ap_addr = 4; ap_wdata = 32'h2000; ap_be = 4'hF;
    @(negedge clk);
    fw_we = 0; fw_be = 0; ap_we = 0; ap_be = 0;
    fw_rd(4, v); chk("R11 no empty on coincident post", v, 32'h0);
    ap_rd(4, v); chk("R11 full stays set", v, 32'h2000);

    // R7 live status
    dma_ready_i = 1; @(negedge clk);
    ap_rd(4, v); chk("R7 ready visible", v, 32'h3000);
    ap_wr(4, 32'h1800, 4'hF);
    ap_rd(4, v); chk("R7 live bits ignore writes", v, 32'h3000);
    dma_ready_i = 0; @(negedge clk);
    ap_rd(4, v); chk("R7 ready follows low", v, 32'h2000);

    // R9/R10 DMA request
    ap_wr(6, 32'h0800, 4'hF);
    chk("R9 drq idle", {31'h0, drq_o}, 32'h0);
    dma_wmark_i = 1; @(negedge clk);
    chk("R9 drq on watermark", {31'h0, drq_o}, 32'h1);
    ap_wr(7, 32'h2, 4'hF);
    chk("R10 drq active-low", {31'h0, drq_o}, 32'h0);
    chk("R10 intr polarity unaffected", {31'h0, intr_o}, 32'h1);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule